// File: doc/BRIEF.md
# Auto-Increment Register Reader on an I2C Target

This block is an I2C target that serves reads from a small register space. A write transaction carries one register-address byte, and that byte loads an internal pointer. After a repeated START the master addresses the target for reading. The target then streams bytes from the pointer, most significant bit first, until the master answers a byte with NACK and closes with STOP. The block holds no storage of its own. It presents the pointer on a read port and takes the byte back combinationally from storage outside the block.

The space has two regions. The display region covers pointer values 0x00 to 0x0F and wraps from its last location back to its first. The key region covers 0x40 to 0x45 and must be read as one continuous burst that begins at 0x40. When a read breaks that rule, the key region returns 0x00 and the block raises a flag. Any other address is refused during the pointer write and reads back as 0xFF.

The bus lines arrive oversampled on the block clock and pass through synchronizers. START and STOP are recognized as SDA edges while SCL is high. The controller state machine has nine states:

- ST_IDLE waits for START.
- ST_RX_ADDR shifts in the target address byte. On a match it moves to ST_ACK_ADDR; otherwise it moves to ST_SKIP.
- ST_ACK_ADDR acknowledges the address. It then moves to ST_RX_REG for a write or to ST_TX for a read.
- ST_RX_REG shifts in the register address and loads the pointer. It moves to ST_ACK_REG if the address is defined, or to ST_SKIP if it is not.
- ST_ACK_REG acknowledges the register address and then moves to ST_SKIP.
- ST_TX drives eight data bits and then moves to ST_TX_ACK.
- ST_TX_ACK samples the master's answer. An ACK advances the pointer and leads to ST_TX_NEXT; a NACK leads to ST_SKIP.
- ST_TX_NEXT loads the next byte on the falling SCL edge and returns to ST_TX.
- ST_SKIP leaves SDA alone until the bus shows START or STOP.

From any state, STOP leads to ST_IDLE and START leads to ST_RX_ADDR.

Top module: `regspace_i2c_reader`

## Requirements
- R1: The target answers only the 7-bit address formed by binary 1110 in the upper four bits and addr_sel_i[2:0] in the lower three. It acknowledges that address by pulling SDA low for the ninth clock. The eighth bit selects the direction: 0 is write, 1 is read. Any other address gets no acknowledge, and SDA stays released for the whole transaction.
- R2: In a write transaction, the byte after the target address loads the pointer. The block acknowledges that byte only when it lies in 0x00–0x0F or 0x40–0x45.
- R3: A read sends the byte at the current pointer, most significant bit first, and rd_addr_o shows the pointer.
- R4: The pointer advances only when the master answers a byte with ACK. After a NACK the pointer stays where it was, so a later read that skips the pointer write starts at the byte that was NACKed.
- R5: In the display region, an advance from 0x0F leads to 0x00.
- R6: A key burst that starts at 0x40 returns the stored key bytes in order. Once the pointer reaches 0x45 it stays there and repeats 0x45.
- R7: A read that starts with the pointer at 0x41–0x45 returns 0x00 for every key-region byte and sets key_err_o.
- R8: A read that starts at 0x40 and ends with NACK on its first byte sets key_err_o. key_err_o holds until the next START, which clears it.
- R9: When the pointer lies outside both regions, reads return 0xFF and the pointer does not move.
- R10: After a NACK from the master, SDA stays released until the next START. A STOP at any bit position releases SDA and returns the block to idle, and it leaves the pointer unchanged.
- R11: sda_pull_o becomes active only while the synchronized SCL is low.
- R12: After reset, sda_pull_o and key_err_o are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_sel_i | input | 3 | Low three bits of the target address |
| rd_data_i | input | 8 | Byte returned by storage for rd_addr_o |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| rd_addr_o | output | 8 | Current pointer, used as the read address |
| key_err_o | output | 1 | Set when a key-region access breaks the burst rule |

## Verification
The assertions assume that SDA changes only while SCL is low, except at START and STOP. They also assume that SCL holds each level for several clocks, so that every synchronized edge is seen once and is separated from data changes. The bench master holds each quarter of an SCL period for eight clocks, and it changes SDA a quarter period after SCL falls. It ends every transaction with STOP. The one exception is a deliberate STOP mid-byte, which the bench issues only while the target is receiving, so the bus is free for it.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] DISP_FIRST = 8'h00;
    localparam logic [BYTE_W-1:0] DISP_LAST  = 8'h0F;
    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h40;
    localparam logic [BYTE_W-1:0] KEY_LAST   = 8'h45;
    localparam logic [BYTE_W-1:0] VOID_BYTE  = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ACK_ADDR,
        ST_RX_REG,
        ST_ACK_REG,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_SKIP
    } rsr_state_e;

    typedef enum logic [1:0] {
        RG_DISP,
        RG_KEY,
        RG_NONE
    } rsr_region_e;

    function automatic rsr_region_e region_of(input logic [BYTE_W-1:0] a);
        if (a <= DISP_LAST)
            return RG_DISP;
        else if (a >= KEY_FIRST && a <= KEY_LAST)
            return RG_KEY;
        else
            return RG_NONE;
    endfunction

endpackage

// File: rtl/rsr_line_sync.sv
module rsr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_raw;
                    sda_ff <= sda_raw;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[STAGES-1];
            sda_q <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl   = scl_ff[STAGES-1];
    assign sda_lvl   = sda_ff[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/rsr_pointer.sv
module rsr_pointer
    import rsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              adv,
    input  logic              burst_bad,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr,
    output rsr_region_e       region,
    output logic [BYTE_W-1:0] tx_byte
);

    logic [BYTE_W-1:0] ptr_next;

    assign region = region_of(ptr);

    always_comb begin
        unique case (region)
            RG_DISP: ptr_next = (ptr == DISP_LAST) ? DISP_FIRST : ptr + 8'd1;
            RG_KEY:  ptr_next = (ptr == KEY_LAST)  ? KEY_LAST   : ptr + 8'd1;
            default: ptr_next = ptr;
        endcase
    end

    always_comb begin
        unique case (region)
            RG_DISP: tx_byte = rd_data;
            RG_KEY:  tx_byte = burst_bad ? '0 : rd_data;
            default: tx_byte = VOID_BYTE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= DISP_FIRST;
        else if (load)
            ptr <= load_val;
        else if (adv)
            ptr <= ptr_next;
    end

    AST_DISP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv) && !$past(load) && $past(ptr) == DISP_LAST |-> ptr == DISP_FIRST); // R5

    AST_KEY_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv) && !$past(load) && $past(ptr) == KEY_LAST |-> ptr == KEY_LAST); // R6

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !adv |=> $stable(ptr)); // R4

    AST_VOID_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && region == RG_NONE |=> $stable(ptr)); // R9

endmodule

// File: rtl/regspace_i2c_reader.sv
module regspace_i2c_reader
    import rsr_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  ADDR_PREFIX = 4'b1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        addr_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] rd_addr_o,
    output logic              key_err_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    rsr_state_e         state, state_nxt;
    logic [BYTE_W-2:0]  rx_sh;
    logic [BYTE_W-1:0]  rx_byte;
    logic [BYTE_W-2:0]  tx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               rw_q;
    logic               first_q;
    logic               bad_q;
    logic               ptr_load;
    logic               ptr_adv;
    logic               start_bad;
    logic               burst_bad;
    logic [BYTE_W-1:0]  ptr;
    logic [BYTE_W-1:0]  tx_byte;
    rsr_region_e        region;

    rsr_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign rx_byte   = {rx_sh, sda_lvl};
    assign start_bad = (region == RG_KEY) && (ptr != KEY_FIRST);
    assign burst_bad = (state == ST_ACK_ADDR) ? start_bad : bad_q;

    rsr_pointer u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_val  (rx_byte),
        .adv       (ptr_adv),
        .burst_bad (burst_bad),
        .rd_data   (rd_data_i),
        .ptr       (ptr),
        .region    (region),
        .tx_byte   (tx_byte)
    );

    assign rd_addr_o = ptr;

    // next-state and strobes
    always_comb begin
        state_nxt = state;
        ptr_load  = 1'b0;
        ptr_adv   = 1'b0;
        if (stop_det) begin
            state_nxt = ST_IDLE;
        end else if (start_det) begin
            state_nxt = ST_RX_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_RX_ADDR:
                    if (scl_rise && bit_cnt == LAST_BIT)
                        state_nxt = (rx_byte[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel_i})
                                    ? ST_ACK_ADDR : ST_SKIP;
                ST_ACK_ADDR:
                    if (scl_fall && sda_pull_o)
                        state_nxt = rw_q ? ST_TX : ST_RX_REG;
                ST_RX_REG:
                    if (scl_rise && bit_cnt == LAST_BIT) begin
                        ptr_load  = 1'b1;
                        state_nxt = (region_of(rx_byte) != RG_NONE) ? ST_ACK_REG : ST_SKIP;
                    end
                ST_ACK_REG:
                    if (scl_fall && sda_pull_o)
                        state_nxt = ST_SKIP;
                ST_TX:
                    if (scl_fall && bit_cnt == LAST_BIT)
                        state_nxt = ST_TX_ACK;
                ST_TX_ACK:
                    if (scl_rise) begin
                        if (!sda_lvl) begin
                            ptr_adv   = 1'b1;
                            state_nxt = ST_TX_NEXT;
                        end else begin
                            state_nxt = ST_SKIP;
                        end
                    end
                ST_TX_NEXT:
                    if (scl_fall)
                        state_nxt = ST_TX;
                ST_SKIP: state_nxt = ST_SKIP;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            key_err_o  <= 1'b0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            bit_cnt    <= '0;
            rw_q       <= 1'b0;
            first_q    <= 1'b0;
            bad_q      <= 1'b0;
        end else if (stop_det) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
        end else if (start_det) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
            key_err_o  <= 1'b0;
            bad_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_RX_ADDR, ST_RX_REG: begin
                    if (scl_rise) begin
                        rx_sh   <= rx_byte[BYTE_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (state == ST_RX_ADDR && bit_cnt == LAST_BIT)
                            rw_q <= sda_lvl;
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        if (!sda_pull_o) begin
                            sda_pull_o <= 1'b1;
                        end else if (rw_q) begin
                            tx_sh      <= tx_byte[BYTE_W-2:0];
                            sda_pull_o <= ~tx_byte[BYTE_W-1];
                            bit_cnt    <= '0;
                            first_q    <= 1'b1;
                            bad_q      <= start_bad;
                            if (start_bad)
                                key_err_o <= 1'b1;
                        end else begin
                            sda_pull_o <= 1'b0;
                            bit_cnt    <= '0;
                        end
                    end
                end
                ST_ACK_REG: begin
                    if (scl_fall)
                        sda_pull_o <= ~sda_pull_o;
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_pull_o <= 1'b0;
                        end else begin
                            bit_cnt    <= bit_cnt + 1'b1;
                            sda_pull_o <= ~tx_sh[BYTE_W-2];
                            tx_sh      <= {tx_sh[BYTE_W-3:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            if (first_q && region == RG_KEY)
                                key_err_o <= 1'b1;
                        end else begin
                            first_q <= 1'b0;
                        end
                    end
                end
                ST_TX_NEXT: begin
                    if (scl_fall) begin
                        tx_sh      <= tx_byte[BYTE_W-2:0];
                        sda_pull_o <= ~tx_byte[BYTE_W-1];
                        bit_cnt    <= '0;
                    end
                end
                ST_IDLE, ST_SKIP: sda_pull_o <= 1'b0;
                default:          sda_pull_o <= 1'b0;
            endcase
        end
    end

    AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl); // R11

    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_pull_o); // R10

    AST_SKIP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP |-> !sda_pull_o); // R10

    AST_ERR_IN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_err_o) |-> region == RG_KEY); // R7

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det && !stop_det |=> !key_err_o); // R8

    AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TX_ACK && scl_rise && sda_lvl |=> $stable(ptr)); // R4

endmodule

// File: tb/regspace_i2c_reader_tb_top.sv
module regspace_i2c_reader_tb_top;

    localparam int Q = 8;
    localparam logic [2:0] PINS = 3'b101;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       key_err;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic [7:0] mem [0:127];
    wire        sda_line = sda_m & ~sda_pull;

    assign rd_data = mem[rd_addr[6:0]];

    regspace_i2c_reader dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .addr_sel_i (PINS),
        .rd_data_i  (rd_data),
        .sda_pull_o (sda_pull),
        .rd_addr_o  (rd_addr),
        .key_err_o  (key_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit quiet = 1'b0;
    bit done  = 1'b0;
    bit pull_q = 1'b0;
    int mptr;
    bit rbit;
    bit [7:0] rbyte;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the bus model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (quiet) check(!sda_pull, "R10 released", sda_pull, 0);
            if (sda_pull && !pull_q) check(!scl_m, "R11 pull with scl low", scl_m, 0);
            pull_q <= sda_pull;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic bit_x(input bit b);
        sda_m = b;    waitq();
        scl_m = 1'b1; waitq();
        rbit = sda_line;
        waitq();
        scl_m = 1'b0; waitq();
    endtask

    // returns 1 in rbit when acknowledged
    task automatic send_byte(input bit [7:0] b);
        for (int i = 7; i >= 0; i--) bit_x(b[i]);
        bit_x(1'b1);
        rbit = ~rbit;
    endtask

    task automatic recv_byte(input bit ack);
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1);
            rbyte[i] = rbit;
        end
        bit_x(~ack);
    endtask

    function automatic bit in_key(input int p);
        return p >= 'h40 && p <= 'h45;
    endfunction

    function automatic bit defined(input int p);
        return p <= 'h0F || in_key(p);
    endfunction

    function automatic int ref_next(input int p);
        if (p == 'h0F) return 0;
        if (p < 'h0F) return p + 1;
        if (p >= 'h40 && p < 'h45) return p + 1;
        return p;
    endfunction

    function automatic int ref_byte(input int p, input bit bad);
        if (p <= 'h0F) return mem[p];
        if (in_key(p)) return bad ? 0 : mem[p];
        return 'hFF;
    endfunction

    task automatic read_burst(input int reg_a, input bit set_ptr, input int n, input string req);
        bit bad;
        bit exp_err;
        quiet = 1'b0;
        bus_start();
        if (set_ptr) begin
            send_byte({4'b1110, PINS, 1'b0});
            check(rbit, {req, " R1 addr ack"}, rbit, 1);
            send_byte(reg_a[7:0]);
            check(rbit == defined(reg_a), {req, " R2 reg ack"}, rbit, defined(reg_a));
            mptr = reg_a;
            bus_start();
        end
        send_byte({4'b1110, PINS, 1'b1});
        check(rbit, {req, " R1 read ack"}, rbit, 1);
        check(rd_addr == mptr[7:0], {req, " R3 rd_addr"}, rd_addr, mptr);
        bad = in_key(mptr) && mptr != 'h40;
        exp_err = bad || (n == 1 && in_key(mptr));
        for (int k = 0; k < n; k++) begin
            int e;
            e = ref_byte(mptr, bad);
            recv_byte(k < n - 1);
            check(rbyte == e[7:0], req, rbyte, e);
            if (k < n - 1) mptr = ref_next(mptr);
        end
        quiet = 1'b1;
        bus_stop();
        waitq();
        check(key_err == exp_err, {req, " key_err"}, key_err, exp_err);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) ^ 'h5A);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(sda_pull == 1'b0, "R12 pull at reset", sda_pull, 0);
        check(key_err == 1'b0, "R12 key_err at reset", key_err, 0);
        check(rd_addr == 8'h00, "R12 pointer at reset", rd_addr, 0);
        rst_n = 1'b1;
        quiet = 1'b1;
        waitq();
        mptr = 0;

        read_burst(0, 1'b0, 1, "R12 R3 read after reset");
        read_burst('h03, 1'b1, 3, "R2 R3 display burst");
        read_burst(0, 1'b0, 2, "R4 resume at nacked byte");
        read_burst('h0E, 1'b1, 4, "R5 display wrap");
        read_burst('h40, 1'b1, 8, "R6 key burst park");
        read_burst('h40, 1'b1, 1, "R8 single key byte");
        read_burst(0, 1'b0, 2, "R8 cleared by start");
        read_burst('h42, 1'b1, 2, "R7 key mid start");
        read_burst('h20, 1'b1, 2, "R9 void address");

        // R1: foreign target address
        quiet = 1'b1;
        bus_start();
        send_byte({4'b1110, 3'b010, 1'b1});
        check(!rbit, "R1 foreign address nack", rbit, 0);
        bus_stop();
        waitq();

        // R10: STOP in the middle of a register byte
        read_burst('h07, 1'b1, 1, "R10 setup");
        quiet = 1'b0;
        bus_start();
        send_byte({4'b1110, PINS, 1'b0});
        check(rbit, "R10 addr ack", rbit, 1);
        quiet = 1'b1;
        bit_x(1'b0); bit_x(1'b0); bit_x(1'b1);
        bus_stop();
        waitq();
        check(rd_addr == 8'h07, "R10 pointer kept after stop", rd_addr, 7);
        read_burst(0, 1'b0, 1, "R10 read after abort");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule